// File: doc/BRIEF.md
# Clock-enable prescaler tree

This block derives every bus, timer, converter and USB rate of a chip from one fast clock. It never creates a new clock net. Each derived rate is a strobe that is high for one fast-clock cycle in each of its periods. Downstream logic runs on the fast clock and qualifies its registers with that strobe. The three possible root sources are also strobes at the block's inputs: the internal oscillator, the external oscillator and the frequency-multiplier output. A small selector picks one of them as the system-rate strobe.

From the system strobe, the main bus prescaler produces the main bus strobe. Two peripheral bus prescalers divide the main bus strobe. Each peripheral bus has a timer strobe that runs at twice that bus rate whenever its prescaler is not 1. A fixed divide-by-8 drives the processor tick timer. An even-ratio divider on the second peripheral bus feeds the converter. The USB strobe is the multiplier strobe passed through unchanged or divided by 1.5.

Every ratio comes from a code input. A code change never cuts a period short: each divider loads its new setting only when it emits a strobe.

Top module: `clk_strobe_tree`

## Requirements
- R1: `src_sel_i` picks the system strobe. Code 0 selects the internal oscillator strobe, code 1 the external oscillator strobe, code 2 the multiplier strobe, and code 3 also selects the internal oscillator strobe. The selection is combinational.
- R2: Main bus code k, for k from 0 to 9, divides the system strobe by 2^k. Codes above 9 act as 9, which is a divide by 512.
- R3: Each peripheral bus code k, for k from 0 to 4, divides the main bus strobe by 2^k. Codes above 4 act as 4, which is a divide by 16.
- R4: At peripheral code 0, a timer strobe equals its bus strobe. At an effective peripheral code k ≥ 1, the timer strobe divides the main bus strobe by 2^(k-1), which is twice the bus rate.
- R5: Converter code v, from 0 to 3, divides the second peripheral bus strobe by 2·(v+1).
- R6: With `usb_frac_i`=0, the USB strobe equals the multiplier strobe. With `usb_frac_i`=1, the multiplier strobes are taken in groups of three: the first two of each group pass and the third is dropped. The output is then two strobes for every three, and never two dropped in a row.
- R7: The tick strobe divides the main bus strobe by 8.
- R8: A new code takes effect only after a divider's next output strobe. The period that is running when the code changes completes at the old length.
- R9: Every output strobe is high only in cycles where its parent strobe is high. At a ratio of 1 it follows the parent strobe in the same cycle.
- R10: While reset is active and all three source strobes are low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| int_osc_en_i | input | 1 | internal oscillator strobe |
| ext_osc_en_i | input | 1 | external oscillator strobe |
| mul_en_i | input | 1 | multiplier output strobe |
| src_sel_i | input | 2 | system source code |
| hbus_code_i | input | 4 | main bus divide code (log2 of ratio) |
| pbus1_code_i | input | 3 | first peripheral bus divide code |
| pbus2_code_i | input | 3 | second peripheral bus divide code |
| adc_code_i | input | 2 | converter divide code |
| usb_frac_i | input | 1 | 1 selects divide by 1.5 for USB |
| sys_en_o | output | 1 | system strobe |
| hbus_en_o | output | 1 | main bus strobe |
| tick_en_o | output | 1 | processor tick strobe |
| pbus1_en_o | output | 1 | first peripheral bus strobe |
| pbus2_en_o | output | 1 | second peripheral bus strobe |
| ptim1_en_o | output | 1 | first bus timer strobe |
| ptim2_en_o | output | 1 | second bus timer strobe |
| adc_en_o | output | 1 | converter strobe |
| usb_en_o | output | 1 | USB strobe |

## Verification
The bench builds the block with its default parameters: a main bus range up to 2^9, peripheral ranges up to 2^4, a tick divide of 8 and four converter steps. At these sizes the longest period under test fits inside a 4096-cycle window. That makes it possible to sweep every main and peripheral code, including the clamped codes above the top, and every converter code on two bus settings. Each measured count is compared with the count the ratio predicts. A directed run from divide-by-512 down to divide-by-1 shows that the running period finishes at its old length. The USB run also checks the run lengths of the 1.5 pattern.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_MUL = 2'd2,
    SRC_ALT = 2'd3
  } src_sel_e;

  localparam int FRAC_GROUP = 3;
endpackage

// File: rtl/strobe_div.sv
module strobe_div #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          parent_i,
  input  logic [CW-1:0] ratio_m1_i,
  output logic          strobe_o
);
  logic [CW-1:0] cnt_q, lim_q;
  logic          hit;

  assign hit      = (cnt_q == lim_q);
  assign strobe_o = parent_i & hit;

  // ratio reloads only on an emitted strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (parent_i) begin
      if (hit) begin
        cnt_q <= '0;
        lim_q <= ratio_m1_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_strobe_in_parent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> parent_i);
  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  assert_ratio_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lim_q) |-> $past(strobe_o));
endmodule

// File: rtl/frac_div.sv
module frac_div
  import clk_tree_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic parent_i,
  input  logic frac_i,
  output logic strobe_o
);
  localparam logic [1:0] LAST_PH = 2'(FRAC_GROUP - 1);

  logic [1:0] ph_q;
  logic       frac_q;

  assign strobe_o = parent_i & (~frac_q | (ph_q != LAST_PH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      frac_q <= 1'b0;
    end else if (parent_i) begin
      if (!frac_q || ph_q == LAST_PH) begin
        ph_q   <= '0;
        frac_q <= frac_i;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assert_usb_in_parent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> parent_i);
  assert_phase_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST_PH);
  assert_phase_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frac_q |-> ph_q == 2'd0);
endmodule

// File: rtl/bus_branch.sv
module bus_branch #(
  parameter int LOG_MAX = 4,
  localparam int CODE_W = $clog2(LOG_MAX + 1),
  localparam int CW     = (LOG_MAX < 1) ? 1 : LOG_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hbus_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              bus_en_o,
  output logic              tim_en_o
);
  logic [CODE_W-1:0] k;
  logic [CW-1:0]     bus_m1, tim_m1;

  always_comb begin
    k      = (int'(code_i) > LOG_MAX) ? CODE_W'(LOG_MAX) : code_i;
    bus_m1 = CW'((32'd1 << k) - 32'd1);
    tim_m1 = (k == '0) ? '0 : CW'((32'd1 << (k - 1'b1)) - 32'd1);
  end

  strobe_div #(.CW(CW)) u_bus_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .parent_i(hbus_en_i),
    .ratio_m1_i(bus_m1), .strobe_o(bus_en_o)
  );

  // timer doubles bus rate unless bus ratio is 1
  strobe_div #(.CW(CW)) u_tim_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .parent_i(hbus_en_i),
    .ratio_m1_i(tim_m1), .strobe_o(tim_en_o)
  );

  assert_bus_in_hbus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> hbus_en_i);
  assert_tim_in_hbus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tim_en_o |-> hbus_en_i);
endmodule

// File: rtl/clk_strobe_tree.sv
module clk_strobe_tree
  import clk_tree_pkg::*;
#(
  parameter int HBUS_LOG_MAX = 9,
  parameter int PBUS_LOG_MAX = 4,
  parameter int TICK_DIV     = 8,
  parameter int ADC_STEPS    = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              int_osc_en_i,
  input  logic                              ext_osc_en_i,
  input  logic                              mul_en_i,
  input  logic [1:0]                        src_sel_i,
  input  logic [$clog2(HBUS_LOG_MAX+1)-1:0] hbus_code_i,
  input  logic [$clog2(PBUS_LOG_MAX+1)-1:0] pbus1_code_i,
  input  logic [$clog2(PBUS_LOG_MAX+1)-1:0] pbus2_code_i,
  input  logic [$clog2(ADC_STEPS)-1:0]      adc_code_i,
  input  logic                              usb_frac_i,
  output logic                              sys_en_o,
  output logic                              hbus_en_o,
  output logic                              tick_en_o,
  output logic                              pbus1_en_o,
  output logic                              pbus2_en_o,
  output logic                              ptim1_en_o,
  output logic                              ptim2_en_o,
  output logic                              adc_en_o,
  output logic                              usb_en_o
);
  localparam int HC_W = $clog2(HBUS_LOG_MAX + 1);
  localparam int PC_W = $clog2(PBUS_LOG_MAX + 1);
  localparam int H_CW = HBUS_LOG_MAX;
  localparam int T_CW = $clog2(TICK_DIV);
  localparam int A_CW = $clog2(2 * ADC_STEPS);
  localparam int NBUS = 2;

  src_sel_e src;
  assign src = src_sel_e'(src_sel_i);

  always_comb begin
    unique case (src)
      SRC_EXT: sys_en_o = ext_osc_en_i;
      SRC_MUL: sys_en_o = mul_en_i;
      default: sys_en_o = int_osc_en_i;
    endcase
  end

  logic [HC_W-1:0] hk;
  logic [H_CW-1:0] h_m1;
  always_comb begin
    hk   = (int'(hbus_code_i) > HBUS_LOG_MAX) ? HC_W'(HBUS_LOG_MAX) : hbus_code_i;
    h_m1 = H_CW'((32'd1 << hk) - 32'd1);
  end

  strobe_div #(.CW(H_CW)) u_hbus_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .parent_i(sys_en_o),
    .ratio_m1_i(h_m1), .strobe_o(hbus_en_o)
  );

  strobe_div #(.CW(T_CW)) u_tick_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .parent_i(hbus_en_o),
    .ratio_m1_i(T_CW'(TICK_DIV - 1)), .strobe_o(tick_en_o)
  );

  logic [NBUS-1:0][PC_W-1:0] p_code;
  logic [NBUS-1:0]           p_en, t_en;
  assign p_code = {pbus2_code_i, pbus1_code_i};

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    bus_branch #(.LOG_MAX(PBUS_LOG_MAX)) u_branch (
      .clk_i(clk_i), .rst_ni(rst_ni), .hbus_en_i(hbus_en_o),
      .code_i(p_code[b]), .bus_en_o(p_en[b]), .tim_en_o(t_en[b])
    );
  end

  assign pbus1_en_o = p_en[0];
  assign pbus2_en_o = p_en[1];
  assign ptim1_en_o = t_en[0];
  assign ptim2_en_o = t_en[1];

  // converter ratio 2*(v+1)
  logic [A_CW-1:0] a_m1;
  assign a_m1 = A_CW'(2 * int'(adc_code_i) + 1);

  strobe_div #(.CW(A_CW)) u_adc_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .parent_i(pbus2_en_o),
    .ratio_m1_i(a_m1), .strobe_o(adc_en_o)
  );

  frac_div u_usb_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .parent_i(mul_en_i),
    .frac_i(usb_frac_i), .strobe_o(usb_en_o)
  );

  assert_sys_from_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |-> (int_osc_en_i | ext_osc_en_i | mul_en_i));
  assert_hbus_in_sys_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hbus_en_o |-> sys_en_o);
  assert_tick_in_hbus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_o |-> hbus_en_o);
  assert_adc_in_pbus2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_en_o |-> pbus2_en_o);
endmodule

// File: tb/clk_strobe_tree_bench.sv
`timescale 1ns/1ps
module clk_strobe_tree_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       int_en = 0, ext_en = 0, mul_en = 0;
  logic [1:0] src = 0;
  logic [3:0] hcode = 0;
  logic [2:0] p1code = 0, p2code = 0;
  logic [1:0] acode = 0;
  logic       frac = 0;
  logic sys_en, hbus_en, tick_en, p1_en, p2_en, t1_en, t2_en, adc_en, usb_en;

  clk_strobe_tree u_clk_strobe_tree (
    .clk_i(clk), .rst_ni(rst_n),
    .int_osc_en_i(int_en), .ext_osc_en_i(ext_en), .mul_en_i(mul_en),
    .src_sel_i(src), .hbus_code_i(hcode), .pbus1_code_i(p1code),
    .pbus2_code_i(p2code), .adc_code_i(acode), .usb_frac_i(frac),
    .sys_en_o(sys_en), .hbus_en_o(hbus_en), .tick_en_o(tick_en),
    .pbus1_en_o(p1_en), .pbus2_en_o(p2_en), .ptim1_en_o(t1_en),
    .ptim2_en_o(t2_en), .adc_en_o(adc_en), .usb_en_o(usb_en)
  );

  int checks = 0, errors = 0;
  int int_per = 0, ext_per = 0, mul_per = 0;
  int n_sys, n_h, n_tk, n_p1, n_p2, n_t1, n_t2, n_adc, n_usb;

  // source strobe generators, updated just after each rising edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      int_en = (int_per != 0) && (c % int_per == 0);
      ext_en = (ext_per != 0) && (c % ext_per == 0);
      mul_en = (mul_per != 0) && (c % mul_per == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int w);
    n_sys = 0; n_h = 0; n_tk = 0; n_p1 = 0; n_p2 = 0;
    n_t1 = 0; n_t2 = 0; n_adc = 0; n_usb = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      n_sys += int'(sys_en); n_h += int'(hbus_en); n_tk += int'(tick_en);
      n_p1 += int'(p1_en); n_p2 += int'(p2_en); n_t1 += int'(t1_en);
      n_t2 += int'(t2_en); n_adc += int'(adc_en); n_usb += int'(usb_en);
    end
  endtask

  task automatic set_cfg(input int s, input int h, input int p1, input int p2,
                         input int a, input bit f);
    @(posedge clk); #1;
    src = 2'(s); hcode = 4'(h); p1code = 3'(p1); p2code = 3'(p2);
    acode = 2'(a); frac = f;
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    wait_cyc(3);
    check("R10 outputs in reset", int'({sys_en, hbus_en, tick_en, p1_en, p2_en,
          t1_en, t2_en, adc_en, usb_en}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    int_per = 1;

    // R2, R7, R9: main bus sweep incl. clamp codes
    for (int k = 0; k <= 11; k++) begin
      int ek, w;
      ek = (k > 9) ? 9 : k;
      w = 4096;
      set_cfg(0, (k == 11) ? 15 : k, 0, 0, 0, 0);
      wait_cyc(600);
      measure(w);
      check($sformatf("R2 hbus code %0d", k), n_h, w >> ek);
      check($sformatf("R7 tick code %0d", k), n_tk, w / (8 << ek));
      if (k == 0) check("R9 hbus follows sys at ratio 1", n_h, n_sys);
    end

    // R3, R4: peripheral sweep incl. clamp
    for (int k = 0; k <= 6; k++) begin
      int ek;
      ek = (k > 4) ? 4 : k;
      set_cfg(0, 0, k, (k + 1) % 5, 0, 0);
      wait_cyc(600);
      measure(1024);
      check($sformatf("R3 pbus1 code %0d", k), n_p1, 1024 >> ek);
      check($sformatf("R4 ptim1 code %0d", k), n_t1, (ek == 0) ? 1024 : 1024 >> (ek - 1));
      check($sformatf("R3 pbus2 code %0d", (k + 1) % 5), n_p2, 1024 >> ((k + 1) % 5));
      check($sformatf("R4 ptim2 code %0d", (k + 1) % 5), n_t2,
            (((k + 1) % 5) == 0) ? 1024 : 1024 >> (((k + 1) % 5) - 1));
    end

    // R5 converter
    for (int c = 0; c <= 2; c += 2) begin
      for (int v = 0; v < 4; v++) begin
        set_cfg(0, 0, 0, c, v, 0);
        wait_cyc(300);
        measure(3840);
        check($sformatf("R5 adc pbus2 %0d code %0d", c, v), n_adc,
              3840 / ((1 << c) * 2 * (v + 1)));
      end
    end

    // R1 source selection
    ext_per = 3; mul_per = 2;
    for (int s = 0; s < 4; s++) begin
      set_cfg(s, 0, 0, 0, 0, 0);
      wait_cyc(20);
      measure(300);
      check($sformatf("R1 sys src %0d", s), n_sys, (s == 1) ? 100 : (s == 2) ? 150 : 300);
      check($sformatf("R1 hbus src %0d", s), n_h, n_sys);
    end

    // R6 USB
    for (int p = 1; p <= 2; p++) begin
      mul_per = p;
      set_cfg(0, 0, 0, 0, 0, 0);
      wait_cyc(20);
      measure(300 * p);
      check($sformatf("R6 usb div1 per %0d", p), n_usb, 300);
      set_cfg(0, 0, 0, 0, 0, 1);
      wait_cyc(20);
      measure(300 * p);
      check($sformatf("R6 usb div1.5 per %0d", p), n_usb, 200);
    end
    begin
      int run_hi = 0, run_lo = 0, max_hi = 0, max_lo = 0;
      mul_per = 1;
      wait_cyc(10);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (usb_en) begin run_hi++; run_lo = 0; end
        else begin run_lo++; run_hi = 0; end
        if (run_hi > max_hi) max_hi = run_hi;
        if (run_lo > max_lo) max_lo = run_lo;
      end
      check("R6 usb max high run", max_hi, 2);
      check("R6 usb max low run", max_lo, 1);
    end

    // R8 change applies at boundary only
    set_cfg(0, 9, 0, 0, 0, 0);
    wait_cyc(600);
    begin
      int guard = 0;
      @(negedge clk);
      while (!hbus_en && guard < 1000) begin @(negedge clk); guard++; end
    end
    @(posedge clk); #1 hcode = 0;
    measure(500);
    check("R8 old period kept", n_h, 0);
    wait_cyc(20);
    measure(50);
    check("R8 new ratio after boundary", n_h, 50);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule